// File: doc/BRIEF.md
# Edge-Select 16-bit GPIO Port

This block is a sixteen-pin general-purpose I/O port attached to a plain 16-bit register bus. Software sets each pin as an input or an output. Output pins are driven from a data-out register. Input pins are brought into the clock domain through a two-flop synchroniser. Each input pin watches for a single transition, and one polarity bit per pin chooses whether that transition is rising or falling.

A recognised transition latches a sticky bit in an event status register and raises one shared interrupt line. Software clears a status bit by writing a one to it. A pin-control register gates which synchronised input levels can be seen through the data-in register.

The bus accepts only halfword (16-bit) accesses. A byte or word access is flagged on an error output and has no effect on any register.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset: data-out 0x0000, direction 0xFFFF (all pins inputs), edge select 0x0000, mask 0x0000, status 0x0000, pin control 0xFFFF. `irq`, `pin_oe` and `pin_out` are all 0.
- R2: Registers sit at byte offsets 0x04 data-out, 0x08 direction, 0x0C edge select, 0x10 mask and 0x18 pin control. Each of these reads back the last halfword written to it.
- R3: A direction bit of 0 makes the pin an output. One clock after a write, `pin_oe` equals the inverse of the direction register and `pin_out` equals data-out AND NOT direction. `pin_out` is never high where `pin_oe` is low.
- R4: An edge-select bit of 1 picks the rising edge. A 0-to-1 change on an armed input pin sets that pin's status bit (offset 0x14), visible three clock edges after the pin changes. A 1-to-0 change sets nothing.
- R5: An edge-select bit of 0 picks the falling edge. A 1-to-0 change sets the status bit, and a 0-to-1 change sets nothing.
- R6: A pin is armed only when its direction bit is 1 and its mask bit is 0. Edges on an output pin or on a masked pin set no status bit.
- R7: `irq` is high exactly while at least one status bit is 1.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R9: A read of offset 0x00 returns the synchronised pin levels ANDed with pin control. Writes to offset 0x00 are ignored.
- R10: The access-size code is 2'b00 byte, 2'b01 halfword and 2'b10 word. Any selected access whose code is not 2'b01 raises `bus_err` in that cycle, writes nothing and reads 0x0000. A halfword access never raises `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| bus_err | output | 1 | Bad access width |
| pin_in | input | 16 | Pin input levels (asynchronous) |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Shared event interrupt |

## Verification
Every pin is swept under both polarity settings. In each case the pin first makes the unselected transition, which must leave status at zero, and then the selected one, which must set that pin's bit alone. This separates a swapped polarity, a wrong bit index and a missed edge.

The direction sweep walks a single output pin across the port, and the pin-control sweep reads one fixed input pattern through several masks. Together these expose any crossed bit or missing AND term.

Masked pins and output pins are toggled to confirm that disarming works. Status bits are cleared one at a time, with zero writes in between, to tell write-one-to-clear apart from a plain overwrite. Byte and word accesses are mixed in to show that they are rejected.

// File: rtl/egp_pkg.sv
`timescale 1ns/1ps
package egp_pkg;
  localparam int unsigned PORT_W = 16;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  localparam logic [ADDR_W-1:0] OFS_DIN  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EDGE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_PCTL = 5'h18;
endpackage

// File: rtl/egp_sync.sv
`timescale 1ns/1ps
module egp_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/egp_edge_detect.sv
`timescale 1ns/1ps
module egp_edge_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] armed,
  output logic [W-1:0] event_hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic went_up, went_down;
    always_comb begin
      went_up      = level[b] & ~prev_q[b];
      went_down    = ~level[b] & prev_q[b];
      event_hit[b] = armed[b] & (rise_sel[b] ? went_up : went_down);
    end
  end
endmodule

// File: rtl/egp_regs.sv
`timescale 1ns/1ps
module egp_regs
  import egp_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_err,
  input  logic [W-1:0]  level,
  input  logic [W-1:0]  event_hit,
  output logic [W-1:0]  rise_sel,
  output logic [W-1:0]  armed,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic [W-1:0] dout_q, dout_d;
  logic [W-1:0] dir_q,  dir_d;
  logic [W-1:0] edge_q, edge_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] pctl_q, pctl_d;
  logic [W-1:0] pout_q, pout_d;
  logic         pout_en;
  logic         acc_ok, wr_en;
  logic [W-1:0] clr_bits;

  assign acc_ok = bus_sel & (bus_size == SZ_HALF);
  assign wr_en  = acc_ok & bus_wr;

  // next-state
  always_comb begin
    dout_d   = dout_q;
    dir_d    = dir_q;
    edge_d   = edge_q;
    mask_d   = mask_q;
    pctl_d   = pctl_q;
    clr_bits = '0;
    if (wr_en) begin
      unique case (bus_addr)
        OFS_DOUT: dout_d   = bus_wdata;
        OFS_DIR:  dir_d    = bus_wdata;
        OFS_EDGE: edge_d   = bus_wdata;
        OFS_MASK: mask_d   = bus_wdata;
        OFS_STAT: clr_bits = bus_wdata;
        OFS_PCTL: pctl_d   = bus_wdata;
        default:  ;
      endcase
    end
    stat_d  = (stat_q & ~clr_bits) | event_hit;
    pout_d  = dout_d & ~dir_d;
    pout_en = (pout_d != pout_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '1;
      edge_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
      pctl_q <= '1;
      pout_q <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      edge_q <= edge_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      pctl_q <= pctl_d;
      if (pout_en) pout_q <= pout_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_wr) begin
      unique case (bus_addr)
        OFS_DIN:  bus_rdata = level & pctl_q;
        OFS_DOUT: bus_rdata = dout_q;
        OFS_DIR:  bus_rdata = dir_q;
        OFS_EDGE: bus_rdata = edge_q;
        OFS_MASK: bus_rdata = mask_q;
        OFS_STAT: bus_rdata = stat_q;
        OFS_PCTL: bus_rdata = pctl_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_err  = bus_sel & (bus_size != SZ_HALF);
  assign rise_sel = edge_q;
  assign armed    = dir_q & ~mask_q;
  assign pin_out  = pout_q;
  assign pin_oe   = ~dir_q;
  assign irq      = |stat_q;
endmodule

// File: rtl/edge_gpio_port.sv
`timescale 1ns/1ps
module edge_gpio_port
  import egp_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_err,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic [1:0]   rst_pipe_q;
  logic         rst_int_n;
  logic [W-1:0] level, rise_sel, armed, event_hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  egp_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(pin_in), .q_sync(level)
  );

  egp_edge_detect #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .level(level), .rise_sel(rise_sel),
    .armed(armed), .event_hit(event_hit)
  );

  egp_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .level(level), .event_hit(event_hit),
    .rise_sel(rise_sel), .armed(armed),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );
endmodule

// File: rtl/egp_checker.sv
`timescale 1ns/1ps
module egp_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    bus_size,
  input logic [AW-1:0] bus_addr,
  input logic          bus_err,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq
);
  logic bad_wr, stat_wr;
  assign bad_wr  = bus_sel && bus_wr && (bus_size != 2'b01);
  assign stat_wr = bus_sel && bus_wr && (bus_size == 2'b01) && (bus_addr == 5'h14);

  p_err_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != 2'b01) |-> bus_err);

  p_no_err_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_size == 2'b01) |-> !bus_err);

  p_bad_write_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  p_out_only_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  p_irq_drop_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr));

  p_irq_rise_needs_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pin_oe) != {W{1'b1}}));
endmodule

bind edge_gpio_port egp_checker #(.W(W), .AW(AW)) u_egp_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_err(bus_err),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_edge_gpio_port.sv
`timescale 1ns/1ps
module test_edge_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_size;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  edge_gpio_port i_edge_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d, output logic e,
                    input logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    d = bus_rdata; e = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d; logic e;
    rd(a, d, e);
    chk(req, d, exp);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d, exp_v;
    logic e;
    bus_sel = 0; bus_wr = 0; bus_size = 2'b01; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; rst_n = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(3);

    // R1 reset state
    expect_reg("R1 dout", 5'h04, 16'h0000);
    expect_reg("R1 dir", 5'h08, 16'hFFFF);
    expect_reg("R1 edge", 5'h0C, 16'h0000);
    expect_reg("R1 mask", 5'h10, 16'h0000);
    expect_reg("R1 stat", 5'h14, 16'h0000);
    expect_reg("R1 pctl", 5'h18, 16'hFFFF);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);

    // R2 read-back
    for (int k = 0; k < 2; k++) begin
      logic [15:0] pat;
      pat = k ? 16'h3C96 : 16'hA5C3;
      wr(5'h0C, pat); expect_reg("R2 edge", 5'h0C, pat);
      wr(5'h10, ~pat); expect_reg("R2 mask", 5'h10, ~pat);
      wr(5'h18, pat ^ 16'h0FF0); expect_reg("R2 pctl", 5'h18, pat ^ 16'h0FF0);
      wr(5'h04, pat); expect_reg("R2 dout", 5'h04, pat);
      wr(5'h08, pat); expect_reg("R2 dir", 5'h08, pat);
    end
    wr(5'h08, 16'hFFFF); wr(5'h04, 16'h0000);
    wr(5'h10, 16'h0000); wr(5'h18, 16'hFFFF);

    // R3 direction and output drive
    wr(5'h04, 16'hFFFF);
    wr(5'h08, 16'hF0F0);
    chk("R3 oe", pin_oe, 16'h0F0F);
    chk("R3 out", pin_out, 16'h0F0F);
    wr(5'h04, 16'h5A5A);
    for (int i = 0; i < 16; i++) begin
      wr(5'h08, ~(16'h1 << i));
      chk("R3 walk oe", pin_oe, 16'h1 << i);
      chk("R3 walk out", pin_out, 16'h5A5A & (16'h1 << i));
    end
    wr(5'h08, 16'hFFFF);
    chk("R3 all input out", pin_out, 16'h0);
    wr(5'h04, 16'h0000);

    // R9 data-in through pin control
    @(negedge clk); pin_in = 16'hBEEF; wait_neg(3);
    foreach (exp_v[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] pc;
      pc = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : (k == 2) ? 16'h00FF : 16'hA5A5;
      wr(5'h18, pc);
      expect_reg("R9 din", 5'h00, 16'hBEEF & pc);
    end
    wr(5'h18, 16'hFFFF);
    wr(5'h00, 16'h0000);
    expect_reg("R9 din write ignored", 5'h00, 16'hBEEF);
    @(negedge clk); pin_in = 16'h0000; wait_neg(4);
    wr(5'h14, 16'hFFFF);
    expect_reg("R9 stat clean", 5'h14, 16'h0000);

    // R4/R5 sweep every pin, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < 16; p++) begin
        wr(5'h0C, pol ? 16'hFFFF : 16'h0000);
        @(negedge clk); pin_in[p] = pol[0]; wait_neg(4);
        wr(5'h14, 16'hFFFF);
        @(negedge clk); pin_in[p] = ~pol[0]; wait_neg(4);
        if (pol) expect_reg("R4 falling ignored", 5'h14, 16'h0000);
        else     expect_reg("R5 rising ignored", 5'h14, 16'h0000);
        @(negedge clk); pin_in[p] = pol[0]; wait_neg(3);
        if (pol) expect_reg("R4 rising sets bit", 5'h14, 16'h1 << p);
        else     expect_reg("R5 falling sets bit", 5'h14, 16'h1 << p);
        chk("R7 irq set", {15'b0, irq}, 16'h1);
        wr(5'h14, 16'h1 << p);
        expect_reg("R8 clear", 5'h14, 16'h0000);
        chk("R7 irq clear", {15'b0, irq}, 16'h0);
      end
      @(negedge clk); pin_in = 16'h0000; wait_neg(4);
      wr(5'h14, 16'hFFFF);
    end

    // R6 masked and output pins
    wr(5'h0C, 16'hFFFF);
    wr(5'h10, 16'h0020);
    @(negedge clk); pin_in[5] = 1'b1; wait_neg(4);
    expect_reg("R6 masked", 5'h14, 16'h0000);
    chk("R6 masked irq", {15'b0, irq}, 16'h0);
    @(negedge clk); pin_in[5] = 1'b0; wait_neg(4);
    wr(5'h10, 16'h0000);
    wr(5'h08, 16'hFFDF);
    @(negedge clk); pin_in[5] = 1'b1; wait_neg(4);
    expect_reg("R6 output pin", 5'h14, 16'h0000);
    chk("R6 output irq", {15'b0, irq}, 16'h0);
    @(negedge clk); pin_in[5] = 1'b0; wait_neg(4);
    wr(5'h08, 16'hFFFF);

    // R8 write-one-to-clear with zero writes
    @(negedge clk); pin_in = 16'h0204; wait_neg(4);
    expect_reg("R8 two events", 5'h14, 16'h0204);
    wr(5'h14, 16'h0000);
    expect_reg("R8 zero write", 5'h14, 16'h0204);
    wr(5'h14, 16'h0004);
    expect_reg("R8 partial clear", 5'h14, 16'h0200);
    chk("R7 irq one left", {15'b0, irq}, 16'h1);
    wr(5'h14, 16'h0200);
    expect_reg("R8 all clear", 5'h14, 16'h0000);
    chk("R7 irq none", {15'b0, irq}, 16'h0);

    // R10 bad access widths
    wr(5'h04, 16'h1234, 2'b00);
    expect_reg("R10 byte write dropped", 5'h04, 16'h0000);
    wr(5'h08, 16'h0000, 2'b10);
    chk("R10 word write oe", pin_oe, 16'h0000);
    rd(5'h08, d, e, 2'b10);
    chk("R10 word read data", d, 16'h0000);
    chk("R10 word read err", {15'b0, e}, 16'h1);
    rd(5'h08, d, e, 2'b00);
    chk("R10 byte read err", {15'b0, e}, 16'h1);
    rd(5'h08, d, e, 2'b01);
    chk("R10 half no err", {15'b0, e}, 16'h0);
    chk("R10 half data", d, 16'hFFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule